// File: doc/BRIEF.md
# Nested Priority-Level Interrupt Controller

This block gathers requests from 32 sources and latches each one in a pending flag on the rising edge of its request input. Software gives each source a 3-bit priority. Priority 0 shuts the source out. The block keeps an in-service mask with one bit per priority, which software maintains. The active-low interrupt line to the CPU goes low only when some pending, unmasked source has a priority strictly above the highest priority marked in service.

The block publishes two values in readable registers: the best qualifying priority and the number of the source that wins it. A handler reads the winning source, then sets the in-service bit for that priority, and this drops the line. Higher priorities can still break through. The handler clears the flag by writing a one to it. On exit it clears its in-service bit, which re-admits that priority and every priority below it.

Access is through a single-cycle register port. A write takes effect on the clock edge. Reads are combinational from the address.

Top module: `nest_irq_ctrl`

## Requirements
- R1: A rising edge on `req_in[n]` sets pending flag n at the next clock edge. The flag stays set until it is cleared, and another rising edge while it is set leaves it set.
- R2: A source whose configured priority is 0 never drives the interrupt line, however long it stays pending.
- R3: `irq_n` is a register. It is 0 in the cycle after the register state shows a pending source with a nonzero priority greater than the highest set in-service bit among bits 1..7. Otherwise it is 1. In-service bit 0 is ignored.
- R4: While that condition holds, the request-level register (address 3, bits 2:0) is loaded with the highest qualifying priority. While it does not hold, the register keeps its previous value.
- R5: While that condition holds, the source-number register (address 4, bits 4:0) is loaded with the number of the winning source. When several sources share the top priority, the lowest-numbered one wins.
- R6: Setting the in-service bit of the priority being served returns `irq_n` to 1 one cycle after the write, provided no higher pending priority exists.
- R7: The pending registers are write-one-to-clear. Address 0 bit n is source n for n = 0..15, and address 1 bit n is source 16+n. A 1 clears the flag and a 0 leaves it unchanged.
- R8: Clearing an in-service bit (address 2, bit p = priority p) lets `irq_n` fall again one cycle later for pending priorities that the bit had blocked.
- R9: When a rising edge on a request and a clear write for the same flag fall in the same cycle, the flag ends up set.
- R10: Priorities are read and written at addresses 8+k. Each of these holds sources 4k..4k+3, with source 4k+j in bits 4j+2..4j; the other bits read 0.
- R11: After reset, `irq_n` is 1, and all pending flags, in-service bits, priorities, the request level and the source number are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_in | input | 32 | Request inputs, one per source, edge-detected |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| irq_n | output | 1 | Active-low interrupt request to the CPU |

## Verification
The bench targets the following corner cases:
- Priority ties at the top level. A design that scanned in the wrong direction would report the higher-numbered source.
- A pending source at exactly the in-service priority. An off-by-one comparison would raise the interrupt when it must stay quiet.
- In-service bit 0. Treating it as a real priority would block level-1 requests.
- A request edge arriving together with a clear write. Giving the clear precedence would lose the request.
- Repeated edges on a flag that is already set. Toggling on those edges would drop the flag.
- Writes of zero to the pending registers. A design that did not implement write-one-to-clear would wipe unrelated flags.
- Priority-0 sources that are pending. A design that leaked them would raise the line.

// File: rtl/nirq_pkg.sv
// Shared sizes and register addresses for the nested interrupt controller.
// Assumes the source count is a multiple of the register width.
package nirq_pkg;
    localparam int NIRQ_SRC   = 32;
    localparam int NIRQ_REG_W = 16;
    localparam int NIRQ_LVL_W = 3;
    localparam int NIRQ_ADDR_W = 5;
    localparam int NIRQ_FLD_W = 4;

    localparam int A_PEND0 = 0;
    localparam int A_ISR   = 2;
    localparam int A_LVL   = 3;
    localparam int A_ID    = 4;
    localparam int A_CFG   = 8;
endpackage

// File: rtl/nirq_pend.sv
// Pending-flag store. Detects rising edges of the request inputs and latches them.
// Flags are cleared by a write-one mask per bank. Set has priority over clear.
// Assumes requests are already synchronous to clk.
module nirq_pend #(
    parameter int NSRC  = 32,
    parameter int REG_W = 16,
    localparam int NBANK = NSRC / REG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  req_in,
    input  logic [NBANK-1:0] clr_we,
    input  logic [REG_W-1:0] clr_data,
    output logic [NSRC-1:0]  pend
);
    logic [NSRC-1:0] req_q;
    logic [NSRC-1:0] rise;
    logic [NSRC-1:0] clr_vec;

    // Remember last request level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= req_in;
    end

    assign rise = req_in & ~req_q;

    genvar b;
    generate
        for (b = 0; b < NBANK; b++) begin : g_bank
            // Build the per-bank clear mask from the write strobe.
            assign clr_vec[b*REG_W +: REG_W] = clr_we[b] ? clr_data : '0;

            // Update this bank's flags: new edges win over clears.
            always_ff @(posedge clk) begin
                if (!rst_n) pend[b*REG_W +: REG_W] <= '0;
                else pend[b*REG_W +: REG_W] <= (pend[b*REG_W +: REG_W] & ~clr_vec[b*REG_W +: REG_W])
                                              | rise[b*REG_W +: REG_W];
            end
        end
    endgenerate

    // R1: a flag not cleared stays set.
    assert_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend & $past(pend & ~clr_vec)) == $past(pend & ~clr_vec)));
    // R1 / R9: an edge always leaves its flag set, even with a clear.
    assert_edge_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend & $past(rise)) == $past(rise)));
    // R7: a cleared flag with no new edge reads zero next cycle.
    assert_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend & $past(clr_vec & ~rise)) == '0));
endmodule

// File: rtl/nirq_cfg.sv
// Configuration store: per-source priority fields and the in-service level mask.
// Bit 0 of the mask has no meaning and is held at zero.
// Also provides readback of the addressed priority register.
module nirq_cfg #(
    parameter int NSRC  = 32,
    parameter int REG_W = 16,
    parameter int LVL_W = 3,
    parameter int FLD_W = 4,
    localparam int NLVL   = 1 << LVL_W,
    localparam int PER    = REG_W / FLD_W,
    localparam int NCFG   = NSRC / PER,
    localparam int CFG_IW = (NCFG > 1) ? $clog2(NCFG) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [CFG_IW-1:0]     cfg_idx,
    input  logic                  isr_we,
    input  logic [REG_W-1:0]      wdata,
    output logic [NSRC*LVL_W-1:0] src_lvl,
    output logic [NLVL-1:0]       isr,
    output logic [REG_W-1:0]      cfg_rdata
);
    logic [LVL_W-1:0] lvl_q [NSRC];

    genvar i;
    generate
        for (i = 0; i < NSRC; i++) begin : g_src
            localparam int IDX = i / PER;
            localparam int FLD = i % PER;
            // Load this source's priority when its register is written.
            always_ff @(posedge clk) begin
                if (!rst_n) lvl_q[i] <= '0;
                else if (cfg_we && (cfg_idx == CFG_IW'(IDX)))
                    lvl_q[i] <= wdata[FLD*FLD_W +: LVL_W];
            end
            assign src_lvl[i*LVL_W +: LVL_W] = lvl_q[i];
        end
    endgenerate

    // Hold the in-service level mask, with bit 0 forced to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)      isr <= '0;
        else if (isr_we) isr <= {wdata[NLVL-1:1], 1'b0};
    end

    // Assemble the addressed priority register for reads.
    always_comb begin
        cfg_rdata = '0;
        for (int j = 0; j < PER; j++)
            cfg_rdata[j*FLD_W +: LVL_W] = lvl_q[int'(cfg_idx)*PER + j];
    end

    // R3: in-service bit 0 never holds a one.
    assert_isr_bit0_R3: assert property (@(posedge clk) disable iff (!rst_n)
        isr_we |=> !isr[0]);
endmodule

// File: rtl/nirq_arb.sv
// Combinational arbiter. Finds the highest nonzero priority among pending sources,
// breaks ties toward the lowest source number, and compares the result with the
// top in-service level. Holds no state.
module nirq_arb #(
    parameter int NSRC  = 32,
    parameter int LVL_W = 3,
    localparam int NLVL = 1 << LVL_W,
    localparam int ID_W = $clog2(NSRC)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NSRC-1:0]       pend,
    input  logic [NSRC*LVL_W-1:0] src_lvl,
    input  logic [NLVL-1:0]       isr,
    output logic                  hit,
    output logic [LVL_W-1:0]      win_lvl,
    output logic [ID_W-1:0]       win_id
);
    logic [LVL_W-1:0] isr_top;

    // Scan from the top source down so equal priorities settle on the lowest number.
    always_comb begin
        logic [LVL_W-1:0] cur;
        win_lvl = '0;
        win_id  = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            cur = pend[i] ? src_lvl[i*LVL_W +: LVL_W] : '0;
            if ((cur != '0) && (cur >= win_lvl)) begin
                win_lvl = cur;
                win_id  = ID_W'(i);
            end
        end
    end

    // Find the highest level marked in service, ignoring bit 0.
    always_comb begin
        isr_top = '0;
        for (int l = 1; l < NLVL; l++)
            if (isr[l]) isr_top = LVL_W'(l);
    end

    assign hit = (win_lvl > isr_top);

    // R2: a winner is pending and has a nonzero priority.
    assert_winner_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (pend[win_id] && (src_lvl[win_id*LVL_W +: LVL_W] != '0)));
    // R3: no hit while the in-service mask covers the top level.
    assert_isr_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        isr[NLVL-1] |-> !hit);
endmodule

// File: rtl/nirq_out.sv
// Output stage. Registers the interrupt line and captures the winning level and
// source only while the interrupt condition holds; otherwise holds them.
module nirq_out #(
    parameter int LVL_W = 3,
    parameter int ID_W  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit,
    input  logic [LVL_W-1:0] win_lvl,
    input  logic [ID_W-1:0]  win_id,
    output logic             irq_n,
    output logic [LVL_W-1:0] lvl_q,
    output logic [ID_W-1:0]  id_q
);
    // Register the line and capture the winner on a hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_n <= 1'b1;
            lvl_q <= '0;
            id_q  <= '0;
        end else begin
            irq_n <= !hit;
            if (hit) begin
                lvl_q <= win_lvl;
                id_q  <= win_id;
            end
        end
    end

    // R4: an asserted line always carries a nonzero published level.
    assert_level_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> (lvl_q != '0));
    // R4 / R5: without a hit the published values hold.
    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> ($stable(lvl_q) && $stable(id_q)));
endmodule

// File: rtl/nest_irq_ctrl.sv
// Top of the nested priority-level interrupt controller.
// Decodes the register port, wires the pending store, configuration, arbiter and
// output stage, and muxes read data. Reads are combinational on bus_addr.
module nest_irq_ctrl
    import nirq_pkg::*;
#(
    parameter int NSRC   = NIRQ_SRC,
    parameter int REG_W  = NIRQ_REG_W,
    parameter int LVL_W  = NIRQ_LVL_W,
    parameter int ADDR_W = NIRQ_ADDR_W,
    parameter int FLD_W  = NIRQ_FLD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   req_in,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              irq_n
);
    localparam int NBANK  = NSRC / REG_W;
    localparam int NLVL   = 1 << LVL_W;
    localparam int ID_W   = $clog2(NSRC);
    localparam int PER    = REG_W / FLD_W;
    localparam int NCFG   = NSRC / PER;
    localparam int CFG_IW = (NCFG > 1) ? $clog2(NCFG) : 1;

    logic [NBANK-1:0]      clr_we;
    logic                  cfg_hit, cfg_we, isr_we;
    logic [CFG_IW-1:0]     cfg_idx;
    logic [NSRC-1:0]       pend;
    logic [NSRC*LVL_W-1:0] src_lvl;
    logic [NLVL-1:0]       isr;
    logic [REG_W-1:0]      cfg_rdata;
    logic                  hit;
    logic [LVL_W-1:0]      win_lvl, lvl_q;
    logic [ID_W-1:0]       win_id, id_q;

    // Decode write strobes for pending banks.
    always_comb begin
        for (int b = 0; b < NBANK; b++)
            clr_we[b] = bus_we && (bus_addr == ADDR_W'(A_PEND0 + b));
    end

    assign cfg_hit = (bus_addr >= ADDR_W'(A_CFG)) && (bus_addr < ADDR_W'(A_CFG + NCFG));
    assign cfg_we  = bus_we && cfg_hit;
    assign cfg_idx = CFG_IW'(bus_addr - ADDR_W'(A_CFG));
    assign isr_we  = bus_we && (bus_addr == ADDR_W'(A_ISR));

    nirq_pend #(.NSRC(NSRC), .REG_W(REG_W)) u_pend (
        .clk(clk), .rst_n(rst_n), .req_in(req_in),
        .clr_we(clr_we), .clr_data(bus_wdata), .pend(pend)
    );

    nirq_cfg #(.NSRC(NSRC), .REG_W(REG_W), .LVL_W(LVL_W), .FLD_W(FLD_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .isr_we(isr_we), .wdata(bus_wdata), .src_lvl(src_lvl),
        .isr(isr), .cfg_rdata(cfg_rdata)
    );

    nirq_arb #(.NSRC(NSRC), .LVL_W(LVL_W)) u_arb (
        .clk(clk), .rst_n(rst_n), .pend(pend), .src_lvl(src_lvl), .isr(isr),
        .hit(hit), .win_lvl(win_lvl), .win_id(win_id)
    );

    nirq_out #(.LVL_W(LVL_W), .ID_W(ID_W)) u_out (
        .clk(clk), .rst_n(rst_n), .hit(hit), .win_lvl(win_lvl), .win_id(win_id),
        .irq_n(irq_n), .lvl_q(lvl_q), .id_q(id_q)
    );

    // Select read data for the addressed register.
    always_comb begin
        bus_rdata = '0;
        for (int b = 0; b < NBANK; b++)
            if (bus_addr == ADDR_W'(A_PEND0 + b)) bus_rdata = pend[b*REG_W +: REG_W];
        if (bus_addr == ADDR_W'(A_ISR)) bus_rdata[NLVL-1:0]  = isr;
        if (bus_addr == ADDR_W'(A_LVL)) bus_rdata[LVL_W-1:0] = lvl_q;
        if (bus_addr == ADDR_W'(A_ID))  bus_rdata[ID_W-1:0]  = id_q;
        if (cfg_hit) bus_rdata = cfg_rdata;
    end

    // R6: once the top priority is in service the line is released next cycle.
    assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (isr_we && bus_wdata[NLVL-1]) |=> ##1 irq_n);
endmodule

// File: tb/sim_nest_irq_ctrl.sv
`timescale 1ns/1ps
module sim_nest_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] req_in = '0;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq_n;
    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    nest_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .req_in(req_in), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_n(irq_n)
    );

    // Vector fields: {request mask[48:17], in-service[16:9], irq expected[8], level[7:5], source[4:0]}
    // Source n has priority n % 8.
    localparam logic [48:0] VEC [10] = '{
        {32'h0000_0001, 8'h00, 1'b0, 3'd0, 5'd0},
        {32'h0000_0022, 8'h00, 1'b1, 3'd5, 5'd5},
        {32'h0000_0022, 8'h20, 1'b0, 3'd0, 5'd0},
        {32'h0000_0022, 8'h10, 1'b1, 3'd5, 5'd5},
        {32'h0000_8080, 8'h00, 1'b1, 3'd7, 5'd7},
        {32'h8000_0000, 8'h40, 1'b1, 3'd7, 5'd31},
        {32'h0000_0100, 8'h00, 1'b0, 3'd0, 5'd0},
        {32'h0003_0000, 8'h01, 1'b1, 3'd1, 5'd17},
        {32'h0C00_0000, 8'h04, 1'b1, 3'd3, 5'd27},
        {32'h0010_0010, 8'h08, 1'b1, 3'd4, 5'd4}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [15:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic pulse(input logic [31:0] m);
        @(negedge clk); req_in = m;
        @(negedge clk); req_in = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] r;
        logic [15:0] f;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        chk("R11 irq_n", {31'd0, irq_n}, 32'd1);
        rd(5'd0, r); chk("R11 pend0", {16'd0, r}, 32'd0);
        rd(5'd1, r); chk("R11 pend1", {16'd0, r}, 32'd0);
        rd(5'd2, r); chk("R11 isr", {16'd0, r}, 32'd0);
        rd(5'd3, r); chk("R11 level", {16'd0, r}, 32'd0);
        rd(5'd4, r); chk("R11 source", {16'd0, r}, 32'd0);
        rd(5'd9, r); chk("R11 prio", {16'd0, r}, 32'd0);

        // R10: program priority n % 8 for every source, check readback
        for (int k = 0; k < 8; k++) begin
            f = '0;
            for (int j = 0; j < 4; j++) f[4*j +: 3] = 3'((4*k + j) % 8);
            wr(5'(8 + k), f);
        end
        rd(5'd9, r); chk("R10 prio reg1", {16'd0, r}, 32'h7654);
        rd(5'd8, r); chk("R10 prio reg0", {16'd0, r}, 32'h3210);

        // Vector table: R2 R3 R4 R5 across priority and mask patterns
        for (int v = 0; v < 10; v++) begin
            wr(5'd0, 16'hFFFF);
            wr(5'd1, 16'hFFFF);
            wr(5'd2, {8'd0, VEC[v][16:9]});
            pulse(VEC[v][48:17]);
            @(negedge clk);
            chk($sformatf("R3 R2 vec%0d irq", v), {31'd0, irq_n}, {31'd0, !VEC[v][8]});
            if (VEC[v][8]) begin
                rd(5'd3, r); chk($sformatf("R4 vec%0d level", v), {16'd0, r}, {29'd0, VEC[v][7:5]});
                rd(5'd4, r); chk($sformatf("R5 vec%0d source", v), {16'd0, r}, {27'd0, VEC[v][4:0]});
            end
        end

        // R6 / R8: nesting by in-service mask
        wr(5'd0, 16'hFFFF); wr(5'd1, 16'hFFFF); wr(5'd2, 16'h0000);
        pulse(32'h0000_0028);            // sources 3 (prio 3) and 5 (prio 5)
        @(negedge clk);
        chk("R3 nest raise", {31'd0, irq_n}, 32'd0);
        wr(5'd2, 16'h0020);
        @(negedge clk);
        chk("R6 mask drops line", {31'd0, irq_n}, 32'd1);
        rd(5'd3, r); chk("R4 level held", {16'd0, r}, 32'd5);
        wr(5'd2, 16'h0000);
        @(negedge clk);
        chk("R8 unmask re-raises", {31'd0, irq_n}, 32'd0);
        wr(5'd0, 16'h0020);              // service of 5 done
        @(negedge clk);
        rd(5'd3, r); chk("R8 lower level next", {16'd0, r}, 32'd3);
        rd(5'd4, r); chk("R5 source next", {16'd0, r}, 32'd3);

        // R7: zero writes keep flags, one writes clear only their bit
        wr(5'd0, 16'h0000);
        rd(5'd0, r); chk("R7 zero write", {16'd0, r}, 32'h0008);
        pulse(32'h0000_0004);
        wr(5'd0, 16'h0008);
        rd(5'd0, r); chk("R7 one clears", {16'd0, r}, 32'h0004);

        // R1: a second edge on a set flag leaves it set
        pulse(32'h0000_0004);
        repeat (3) @(negedge clk);
        rd(5'd0, r); chk("R1 sticky", {16'd0, r}, 32'h0004);

        // R9: edge and clear in the same cycle
        @(negedge clk);
        bus_addr = 5'd0; bus_wdata = 16'h0004; bus_we = 1'b1; req_in = 32'h0000_0004;
        @(negedge clk);
        bus_we = 1'b0; req_in = '0;
        rd(5'd0, r); chk("R9 set wins", {16'd0, r}, 32'h0004);

        // R2: a pending priority-0 source alone does not raise the line
        wr(5'd0, 16'hFFFF);
        pulse(32'h0000_0001);
        repeat (2) @(negedge clk);
        rd(5'd0, r); chk("R2 flag set", {16'd0, r}, 32'h0001);
        chk("R2 masked quiet", {31'd0, irq_n}, 32'd1);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule